// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory bus. A fast system clock samples the bus clock and data lines. The block pulls the data line low through an open-drain enable and never drives it high. It recognises bus start, stop and repeated start. It matches a seven-bit device address, which is a fixed upper nibble followed by three strap inputs. It then takes a two-byte word address into a single internal address counter.

Data lives in an on-chip byte array of `2**ADDR_BITS` locations. The word address can carry up to 14 active bits, and address bits above `ADDR_BITS` are ignored. The block serves these transfers:

- **Writes.** The master sends data bytes after the word address. Each byte is committed at its acknowledge, unless the write-protect input is high around that acknowledge. The counter advances only within the current page, so a long write wraps back to the start of the same page.
- **Current-address reads.** A read address sent with no word address returns the byte at the counter.
- **Random reads.** The master sends the word address, then a repeated start and a read address. The block returns the byte at the loaded address.
- **Sequential reads.** The master keeps acknowledging, and the block keeps sending. The counter runs through the whole array and wraps from the last location to 0.

After any access the counter points one past the last byte touched.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, sda_oe is 0. The block also holds sda_oe at 0 whenever it is idle.
- R2: A START is a data fall while the clock is high. The first byte after it is received MSB first, with bits 7..1 forming the device address and bit 0 the R/W flag (1 = read). When bits 7..1 equal {DEV_ID, strap_i}, the block drives an ACK (data low) during the ninth clock.
- R3: On a device address mismatch, the block gives no ACK. It then ignores all bus traffic until the next START.
- R4: After a write address, the block acknowledges two word-address bytes, high byte first. The counter is loaded from the low ADDR_BITS bits of {high, low}. All higher bits are don't-care.
- R5: Each data byte after the word address is acknowledged and stored at the counter. The counter then increments only in its low PAGE_BITS bits, so it wraps to the start of the same page.
- R6: A data byte is not stored if wp_i is high at the rising or the falling edge of its acknowledge clock. The byte is still acknowledged, and the counter still advances.
- R7: A read address received right after START returns, MSB first, the byte at the current counter value.
- R8: A write address followed by a word address, then a repeated START and a read address, returns the byte at the loaded address.
- R9: Each master ACK (data low on the ninth clock of a read byte) makes the block send the next location. Reading past the last location wraps to address 0.
- R10: A master NoACK ends the read. The block releases the data line and waits for the next START, after which it serves a new transfer normally.
- R11: A STOP (data rising while the clock is high) in the middle of a byte ends the transfer. Memory is left unchanged.
- R12: After a write or read, the counter points one location past the last byte accessed. A following current-address read continues from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull the data line low when 1 |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, high blocks data writes |

## Verification
The bench builds the block with ADDR_BITS = 9 and PAGE_BITS = 4, so the array has 512 bytes and a page has 16 bytes. With these values, both the in-page wrap and the wrap at the end of memory are reached within a handful of bytes. The bench also sends high address bytes with the bits above bit 8 set, which shows that those bits are ignored. The strap is set to 3'b101, so an address that differs only in a strap bit is tried as a mismatch. Random write bursts of up to 12 bytes at random offsets often cross page ends, and a bench model of both wrap rules checks them.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT,
      ST_RACK
   } ee_state_e;

   localparam int BYTE_W   = 8;
   localparam int MAX_AW   = 14;
   localparam int WORD_A_W = 16;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_ee_sync: STAGES must be at least 2");
      end
   endgenerate

   // Idle bus is high on both lines, so the pipes reset to 1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_ee_addr_ctr.sv
module i2c_ee_addr_ctr #(
   parameter int AW = 11,
   parameter int PB = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_seq,
   input  logic          inc_page,
   output logic [AW-1:0] ptr
);

   localparam int HIGH_W = AW - PB;

   logic [AW-1:0] ptr_seq;
   logic [AW-1:0] ptr_page;

   assign ptr_seq = ptr + 1'b1;

   generate
      if (HIGH_W > 0) begin : g_paged
         logic [PB-1:0] low_next;
         assign low_next = ptr[PB-1:0] + 1'b1;
         assign ptr_page = {ptr[AW-1:PB], low_next};
      end else begin : g_flat
         assign ptr_page = ptr_seq;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_page) ptr <= ptr_page;
      else if (inc_seq)  ptr <= ptr_seq;
   end

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] arr [DEPTH];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int         ADDR_BITS   = 11,
   parameter int         PAGE_BITS   = 6,
   parameter logic [3:0] DEV_ID      = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   import i2c_ee_pkg::*;

   localparam int BW = BYTE_W;

   generate
      if (ADDR_BITS > MAX_AW || ADDR_BITS < 1) begin : g_bad_aw
         $error("i2c_eeprom_slave: ADDR_BITS out of range");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_BITS) begin : g_bad_pb
         $error("i2c_eeprom_slave: PAGE_BITS must be below ADDR_BITS");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ee_state_e               state;
   logic [3:0]              bcnt;
   logic [BW-1:0]           shreg;
   logic [BW-1:0]           tx;
   logic [BW-1:0]           hi_q;
   logic                    ack_ph;
   logic                    wp_seen;
   logic                    mack;

   logic [ADDR_BITS-1:0]    ptr;
   logic [ADDR_BITS-1:0]    load_val;
   logic [WORD_A_W-1:0]     word_addr;
   logic [BW-1:0]           rdata;
   logic                    ack_end;
   logic                    dev_match;
   logic                    mem_we;
   logic                    ctr_load;
   logic                    inc_page;
   logic                    rd_load;
   logic                    no_event;

   assign word_addr = {hi_q, shreg};
   assign load_val  = word_addr[ADDR_BITS-1:0];
   assign dev_match = (shreg[BW-1:1] == {DEV_ID, strap_i});
   assign ack_end   = scl_fall & ack_ph;
   assign no_event  = ~start_det & ~stop_det;

   // Control strobes for the counter and the array.
   always_comb begin
      mem_we   = 1'b0;
      ctr_load = 1'b0;
      inc_page = 1'b0;
      rd_load  = 1'b0;
      if (no_event) begin
         case (state)
            ST_DEV:  rd_load  = ack_end & shreg[0];
            ST_ALO:  ctr_load = ack_end;
            ST_WDAT: begin
               inc_page = ack_end;
               mem_we   = ack_end & ~wp_seen & ~wp_i;
            end
            ST_RACK: rd_load  = scl_fall & ~mack;
            default: ;
         endcase
      end
   end

   i2c_ee_addr_ctr #(.AW(ADDR_BITS), .PB(PAGE_BITS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (load_val),
      .inc_seq  (rd_load),
      .inc_page (inc_page),
      .ptr      (ptr)
   );

   i2c_ee_mem #(.AW(ADDR_BITS), .DW(BW)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (ptr),
      .wdata (shreg),
      .raddr (ptr),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bcnt    <= '0;
         shreg   <= '0;
         tx      <= '0;
         hi_q    <= '0;
         ack_ph  <= 1'b0;
         wp_seen <= 1'b0;
         mack    <= 1'b1;
         sda_oe  <= 1'b0;
      end else if (start_det) begin
         state  <= ST_DEV;
         bcnt   <= '0;
         ack_ph <= 1'b0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         bcnt   <= '0;
         ack_ph <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
               if (scl_rise && !ack_ph && bcnt < 4'd8) begin
                  shreg <= {shreg[BW-2:0], sda_s};
                  bcnt  <= bcnt + 4'd1;
               end
               if (scl_rise && ack_ph) begin
                  wp_seen <= wp_i;
               end
               if (scl_fall && !ack_ph && bcnt == 4'd8) begin
                  if (state == ST_DEV && !dev_match) begin
                     state <= ST_IDLE;
                  end else begin
                     ack_ph <= 1'b1;
                     sda_oe <= 1'b1;
                  end
               end
               if (ack_end) begin
                  ack_ph <= 1'b0;
                  bcnt   <= '0;
                  sda_oe <= 1'b0;
                  case (state)
                     ST_DEV: begin
                        if (shreg[0]) begin
                           state  <= ST_RDAT;
                           tx     <= rdata;
                           sda_oe <= ~rdata[BW-1];
                        end else begin
                           state <= ST_AHI;
                        end
                     end
                     ST_AHI: begin
                        hi_q  <= shreg;
                        state <= ST_ALO;
                     end
                     ST_ALO:  state <= ST_WDAT;
                     default: state <= ST_WDAT;
                  endcase
               end
            end
            ST_RDAT: begin
               if (scl_fall) begin
                  if (bcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     bcnt   <= '0;
                     state  <= ST_RACK;
                  end else begin
                     tx     <= {tx[BW-2:0], 1'b0};
                     sda_oe <= ~tx[BW-2];
                     bcnt   <= bcnt + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) mack <= sda_s;
               if (scl_fall) begin
                  if (!mack) begin
                     tx     <= rdata;
                     sda_oe <= ~rdata[BW-1];
                     state  <= ST_RDAT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
   parameter int AW = 11,
   parameter int PB = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  sda_oe,
   input i2c_ee_pkg::ee_state_e state,
   input logic                  mem_we,
   input logic                  wp_i,
   input logic                  inc_page,
   input logic                  rd_load,
   input logic [AW-1:0]         ptr
);

   import i2c_ee_pkg::*;

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R2
   oe_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !start_det && !stop_det) |-> !scl_s);

   // R5
   page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_page |=> (ptr[AW-1:PB] == $past(ptr[AW-1:PB])) &&
                   (ptr[PB-1:0] == PB'($past(ptr[PB-1:0]) + 1'b1)));

   // R6
   protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !wp_i);

   // R9
   seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (ptr == AW'($past(ptr) + 1'b1)));

   // R11
   stop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |-> !mem_we);

   // R11
   write_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !scl_s);

endmodule

bind i2c_eeprom_slave i2c_ee_chk #(.AW(ADDR_BITS), .PB(PAGE_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe),
   .state     (state),
   .mem_we    (mem_we),
   .wp_i      (wp_i),
   .inc_page  (inc_page),
   .rd_load   (rd_load),
   .ptr       (ptr)
);

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;

   localparam int AW    = 9;
   localparam int PB    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int Q     = 5;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_w;

   int total = 0;
   int fails = 0;
   int mptr = 0;
   logic [7:0] model [DEPTH];
   bit         known [DEPTH];

   always #4 clk = ~clk;

   assign sda_w = !(m_low || sda_oe);

   i2c_eeprom_slave #(.ADDR_BITS(AW), .PAGE_BITS(PB)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (sda_w),
      .sda_oe  (sda_oe),
      .strap_i (STRAP),
      .wp_i    (wp)
   );

   function automatic int page_next(int a);
      return (a & ~((1 << PB) - 1)) | ((a + 1) & ((1 << PB) - 1));
   endfunction

   function automatic int seq_next(int a);
      return (a + 1) % DEPTH;
   endfunction

   task automatic cw(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic i2c_start();
      m_low = 1'b0; cw(Q);
      m_scl = 1'b1; cw(Q);
      m_low = 1'b1; cw(Q);
      m_scl = 1'b0; cw(Q);
   endtask

   task automatic i2c_stop();
      m_low = 1'b1; cw(Q);
      m_scl = 1'b1; cw(Q);
      m_low = 1'b0; cw(Q);
   endtask

   task automatic send_bit(bit b);
      m_low = !b; cw(Q);
      m_scl = 1'b1; cw(2 * Q);
      m_scl = 1'b0; cw(Q);
   endtask

   task automatic recv_bit(output bit b);
      m_low = 1'b0; cw(Q);
      m_scl = 1'b1; cw(Q);
      b = sda_w; cw(Q);
      m_scl = 1'b0; cw(Q);
   endtask

   task automatic send_byte(logic [7:0] d, output bit ack_n);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(ack_n);
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit nack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(nack);
   endtask

   function automatic logic [7:0] dev_byte(bit rd);
      return {4'b1010, STRAP, rd};
   endfunction

   // Word address phase: START, write address, high and low bytes.
   task automatic addr_phase(logic [7:0] hi, logic [7:0] lo, inout bit bad);
      bit a;
      i2c_start();
      send_byte(dev_byte(1'b0), a); bad |= a;
      send_byte(hi, a);             bad |= a;
      send_byte(lo, a);             bad |= a;
   endtask

   task automatic wr_burst(int addr, int n, bit prot, logic [7:0] hi_junk, string req);
      bit bad = 1'b0;
      bit a;
      int p = addr;
      logic [7:0] d;
      addr_phase(hi_junk | 8'(addr >> 8), 8'(addr), bad);
      wp = prot;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         send_byte(d, a); bad |= a;
         if (!prot) begin
            model[p] = d;
            known[p] = 1'b1;
         end
         p = page_next(p);
      end
      i2c_stop();
      wp = 1'b0;
      mptr = p;
      check(!bad, req, int'(bad), 0);
   endtask

   task automatic rd_bytes(int n, string req);
      logic [7:0] d;
      for (int i = 0; i < n; i++) begin
         recv_byte(d, i == n - 1);
         if (known[mptr]) check(d == model[mptr], req, d, model[mptr]);
         mptr = seq_next(mptr);
      end
      i2c_stop();
      cw(2);
      check(sda_oe == 1'b0, "R10", sda_oe, 0);
   endtask

   task automatic rd_rand(int addr, int n, string req);
      bit bad = 1'b0;
      bit a;
      addr_phase(8'(addr >> 8), 8'(addr), bad);
      i2c_start();
      send_byte(dev_byte(1'b1), a); bad |= a;
      check(!bad, "R8", int'(bad), 0);
      mptr = addr;
      rd_bytes(n, req);
   endtask

   task automatic rd_cur(int n, string req);
      bit a;
      i2c_start();
      send_byte(dev_byte(1'b1), a);
      check(a == 1'b0, "R7", a, 0);
      rd_bytes(n, req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
   end

   initial begin
      bit a;
      int ad;
      int ln;
      process::self().srandom(32'h5eed1);
      void'($urandom(32'h5eed1));
      for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

      cw(5);
      check(sda_oe == 1'b0, "R1", sda_oe, 0);
      rst_n = 1'b1;
      cw(5);
      check(sda_oe == 1'b0, "R1", sda_oe, 0);

      // R3: strap bit 1 flipped, then a further byte, both unanswered.
      i2c_start();
      send_byte({4'b1010, 3'b111, 1'b0}, a);
      check(a == 1'b1, "R3", a, 1);
      send_byte(8'h00, a);
      check(a == 1'b1, "R3", a, 1);
      send_byte(dev_byte(1'b0), a);
      check(a == 1'b1, "R3", a, 1);
      i2c_stop();

      // R2 R5: full page near the top of memory.
      wr_burst(9'h1F0, 16, 1'b0, 8'h00, "R2");
      rd_rand(9'h1F0, 16, "R5");

      // R5: burst crossing the page end wraps to the page start.
      wr_burst(9'h1FE, 4, 1'b0, 8'h00, "R5");
      rd_rand(9'h1F0, 2, "R5");
      rd_rand(9'h1FE, 2, "R5");

      // R4: high byte carries set don't-care bits.
      wr_burst(9'h005, 3, 1'b0, 8'hFE, "R4");
      rd_rand(9'h005, 3, "R4");

      // R9: sequential read across the end of memory.
      wr_burst(9'h000, 16, 1'b0, 8'h00, "R9");
      rd_rand(9'h1FE, 4, "R9");

      // R7 R12: current reads continue where the last access ended.
      rd_cur(2, "R7");
      wr_burst(9'h0A3, 2, 1'b0, 8'h00, "R12");
      rd_cur(3, "R12");

      // R6: protected burst over written data leaves it intact.
      wr_burst(9'h040, 4, 1'b0, 8'h00, "R6");
      wr_burst(9'h040, 4, 1'b1, 8'h00, "R6");
      rd_rand(9'h040, 4, "R6");
      rd_cur(1, "R6");

      // R11: STOP after four data bits.
      wr_burst(9'h120, 1, 1'b0, 8'h00, "R11");
      begin
         bit bad = 1'b0;
         addr_phase(8'h01, 8'h20, bad);
         for (int i = 0; i < 4; i++) send_bit(~model[9'h120][7 - i]);
         i2c_stop();
         check(!bad, "R11", int'(bad), 0);
      end
      rd_rand(9'h120, 1, "R11");

      // R10: new transfer after a NoACK and STOP.
      rd_cur(1, "R10");

      // Random bursts and reads.
      for (int it = 0; it < 12; it++) begin
         ad = int'($urandom_range(DEPTH - 1, 0));
         ln = int'($urandom_range(12, 1));
         wr_burst(ad, ln, 1'b0, 8'(($urandom_range(63, 0)) << 2) & 8'hFE, "R5");
         rd_rand(ad & ~((1 << PB) - 1), 1 << PB, "R5");
      end

      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
   end

endmodule